// File: doc/BRIEF.md
# Serial EEPROM-Style I2C Read Target

This block is an I2C target that makes a byte-addressed memory look like a serial EEPROM to a bus master. It watches the open-drain SCL and SDA lines through samples taken on a fast system clock. It detects START, repeated START and STOP conditions and matches a 7-bit device address. On a write header it collects a two-byte word address into an internal pointer. On a read header it streams bytes from the memory read port, starting at that pointer and stepping it by one per byte.

The pointer persists across transactions. A read without a preceding address write (a current-address read) continues where the last one stopped. A random read is an address write, then a repeated START and a read header. A sequential read continues until the master answers a byte with NACK. An input `busy` makes the target refuse its own address, so the master can retry later. The target never holds SCL low. Each byte is fetched from a combinational read port at the SCL falling edge that ends the acknowledge clock, so it is ready at once.

Top module: `i2c_eeprom_rd`

## Requirements
- R1: After reset, `sda_oe` is 0 (SDA released) and the pointer is 0, so the first current-address read returns the byte at location 0.
- R2: A header whose upper 7 bits equal `DEV_ADDR` (default 7'h50) is acknowledged by driving SDA low in the ninth clock. Any other address gets no acknowledge, and SDA stays released until the next START.
- R3: After a write header (bit 0 = 0), the target acknowledges every byte. The first byte is the high address byte and the second is the low address byte. The pointer is loaded with the low 12 bits of {high, low}. Later bytes are acknowledged and change nothing.
- R4: After a read header (bit 0 = 1), the target sends, MSB first, the memory byte at the current pointer.
- R5: A write of two address bytes, followed by a repeated START and a read header, returns data starting at the newly written address.
- R6: The pointer advances by one for every byte sent, including the last byte of a read. A later current-address read therefore starts at the next location.
- R7: A master ACK after a data byte makes the target send the next byte. A master NACK makes it release SDA and ignore the bus until the next START.
- R8: While `busy` is 1 during the header, the target does not acknowledge its own address, drives nothing, and leaves the pointer unchanged.
- R9: The pointer wraps from 12'hFFF to 12'h000.
- R10: `sda_oe` never changes while SCL is high; it changes only after SCL falling edges.
- R11: A START seen part-way through a byte abandons that byte. A complete header then decodes normally, and the pointer is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| busy | input | 1 | When 1, the target refuses its own address |
| mem_rdata | input | 8 | Byte at `mem_addr`, returned combinationally |
| mem_addr | output | AW (12) | Memory read address, equal to the pointer |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench goes after the pointer corners. It checks the wrap from the top location to zero, the increment after a NACKed final byte, and the reload through a repeated START. A design that advanced only on ACKed bytes, or that cleared the pointer on START, would return the wrong byte on the next current-address read. It also drives a foreign address, a busy header, and extra write bytes after the address. It watches every clock for SDA being driven when it must be released, so a target that acknowledged in the wrong case, or kept sending after a NACK, is caught in the ninth clock. A START injected in the middle of a header checks that the bit counter restarts; a target that kept counting would misframe the next header and never acknowledge it.

// File: rtl/i2c_eeprom_rd.sv
module i2c_eeprom_rd #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          busy,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          sda_oe
);
  typedef enum logic [2:0] {IDLE, HDR, WRX, TX, MACK} st_t;

  logic [2:0] scl_p, sda_p;
  logic scl_s, scl_q, sda_s, sda_q, rise, fall, start, stop;
  st_t st;
  logic [3:0] cnt;
  logic [7:0] sh, tx, hi;
  logic [1:0] nwr;
  logic inack, rw, drv;
  logic [AW-1:0] ptr;

  assign scl_s = scl_p[1];
  assign scl_q = scl_p[2];
  assign sda_s = sda_p[1];
  assign sda_q = sda_p[2];
  assign rise  = scl_s & ~scl_q;
  assign fall  = ~scl_s & scl_q;
  assign start = scl_s & scl_q & sda_q & ~sda_s;
  assign stop  = scl_s & scl_q & ~sda_q & sda_s;
  assign mem_addr = ptr;
  assign sda_oe = drv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; sh <= '0; tx <= '0; hi <= '0; nwr <= '0;
      inack <= 1'b0; rw <= 1'b0; drv <= 1'b0; ptr <= '0;
    end else if (start) begin
      st <= HDR; cnt <= '0; inack <= 1'b0; drv <= 1'b0; nwr <= '0;
    end else if (stop) begin
      st <= IDLE; inack <= 1'b0; drv <= 1'b0;
    end else begin
      case (st)
        HDR, WRX: begin
          if (rise && cnt != 4'd8) begin
            sh <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (fall && cnt == 4'd8) begin
            if (!inack) begin
              if (st == HDR) begin
                if (sh[7:1] == DEV_ADDR && !busy) begin
                  drv <= 1'b1; inack <= 1'b1; rw <= sh[0];
                end else st <= IDLE;
              end else begin
                drv <= 1'b1; inack <= 1'b1;
                if (nwr == 2'd0) hi <= sh;
                else if (nwr == 2'd1) ptr <= AW'({hi, sh});
                if (nwr != 2'd2) nwr <= nwr + 2'd1;
              end
            end else begin
              inack <= 1'b0; cnt <= '0;
              if (st == HDR && rw) begin
                st <= TX; tx <= mem_rdata; drv <= ~mem_rdata[7]; ptr <= ptr + 1'b1;
              end else begin
                st <= WRX; drv <= 1'b0;
              end
            end
          end
        end
        TX: begin
          if (rise && cnt != 4'd8) cnt <= cnt + 4'd1;
          else if (fall) begin
            if (cnt == 4'd8) begin
              drv <= 1'b0; st <= MACK; cnt <= '0;
            end else begin
              tx <= {tx[6:0], 1'b0}; drv <= ~tx[6];
            end
          end
        end
        MACK: begin
          if (rise) begin
            sh[0] <= sda_s; cnt <= 4'd1;
          end else if (fall && cnt == 4'd1) begin
            cnt <= '0;
            if (!sh[0]) begin
              st <= TX; tx <= mem_rdata; drv <= ~mem_rdata[7]; ptr <= ptr + 1'b1;
            end else st <= IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE) |-> !sda_oe);

  assert_busy_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HDR && busy && fall && cnt == 4'd8 && !inack && !start && !stop) |=> !sda_oe);

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != WRX) |=> (ptr == $past(ptr) || ptr == $past(ptr) + 1'b1));

  assert_sda_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q && $past(scl_s && scl_q) && !$past(start || stop)) |-> $stable(sda_oe));
endmodule

// File: tb/i2c_eeprom_rd_test.sv
module i2c_eeprom_rd_test;
  localparam int CLK_PERIOD = 10;
  localparam int H = 20;
  localparam int Q = 5;

  logic clk = 0, rst_n = 0, scl = 1, m_low = 0, busy = 0;
  logic [7:0] mem_rdata;
  logic [11:0] mem_addr;
  logic sda_oe, sda;
  int checks = 0, failures = 0, mptr = 0;
  logic watch = 0, exp_oe = 0, prev_oe = 0, prev_hi = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] memb(input int a);
    return 8'((a * 37 + (a >> 5)) ^ 'h5A);
  endfunction

  assign sda = !(m_low || sda_oe);
  assign mem_rdata = memb(int'(mem_addr));

  i2c_eeprom_rd uut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .busy(busy),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .sda_oe(sda_oe));

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (watch && scl) begin
      checks++;
      if (sda_oe !== exp_oe) begin
        failures++;
        $display("FAIL %s sda_oe actual=%0b expected=%0b", tag, sda_oe, exp_oe);
      end
      if (prev_hi) begin
        checks++;
        if (sda_oe !== prev_oe) begin
          failures++;
          $display("FAIL R10 sda_oe changed with SCL high actual=%0b expected=%0b", sda_oe, prev_oe);
        end
      end
    end
    prev_hi = watch && scl;
    prev_oe = sda_oe;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 0; wt(H); scl = 1; wt(H); m_low = 1; wt(H); scl = 0;
  endtask

  task automatic bus_stop();
    wt(Q); m_low = 1; wt(H); scl = 1; wt(H); m_low = 0; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string t);
    logic ack;
    tag = t;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); m_low = ~b[i]; exp_oe = 0; wt(H - Q); scl = 1; wt(H); scl = 0;
    end
    wt(Q); m_low = 0; exp_oe = exp_ack; wt(H - Q); scl = 1;
    wt(H/2); ack = !sda; wt(H/2); scl = 0;
    exp_oe = 0;
    chk({t, " ack"}, int'(ack), int'(exp_ack));
  endtask

  task automatic recv_byte(input logic [7:0] e, input logic mack, input string t);
    logic [7:0] got;
    tag = t;
    for (int i = 7; i >= 0; i--) begin
      exp_oe = ~e[i]; wt(H); scl = 1; wt(H/2); got[i] = sda; wt(H/2); scl = 0;
    end
    exp_oe = 0;
    wt(Q); m_low = mack; wt(H - Q); scl = 1; wt(H); scl = 0; wt(Q); m_low = 0;
    chk({t, " data"}, int'(got), int'(e));
  endtask

  task automatic rd_seq(input int n, input string t);
    for (int i = 0; i < n; i++) begin
      recv_byte(memb(mptr), i != n - 1, t);
      mptr = (mptr + 1) % 4096;
    end
  endtask

  task automatic wr_addr(input logic [15:0] a, input string t);
    bus_start();
    send_byte(8'hA0, 1, t);
    send_byte(a[15:8], 1, t);
    send_byte(a[7:0], 1, t);
    mptr = int'(a[11:0]);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wt(5); rst_n = 1; wt(5);
    chk("R1 reset sda_oe", int'(sda_oe), 0);
    watch = 1;

    bus_start(); send_byte(8'hA1, 1, "R4"); rd_seq(2, "R1 R4 R7"); bus_stop();

    wr_addr(16'h1234, "R3"); bus_stop();
    bus_start(); send_byte(8'hA1, 1, "R4"); rd_seq(1, "R3 R4"); bus_stop();

    wr_addr(16'h0100, "R5"); bus_start(); send_byte(8'hA1, 1, "R5");
    rd_seq(3, "R5 R7"); bus_stop();

    bus_start(); send_byte(8'hA1, 1, "R6"); rd_seq(1, "R6"); bus_stop();

    wr_addr(16'h0050, "R3"); send_byte(8'hAA, 1, "R3 extra"); send_byte(8'h55, 1, "R3 extra");
    bus_stop();
    bus_start(); send_byte(8'hA1, 1, "R3"); rd_seq(1, "R3 discard"); bus_stop();

    bus_start(); send_byte(8'hA3, 0, "R2 foreign"); send_byte(8'hFF, 0, "R2 silent"); bus_stop();

    busy = 1;
    bus_start(); send_byte(8'hA1, 0, "R8 busy"); bus_stop();
    busy = 0;
    bus_start(); send_byte(8'hA1, 1, "R8"); rd_seq(1, "R8 ptr kept"); bus_stop();

    wr_addr(16'h0FFF, "R9"); bus_start(); send_byte(8'hA1, 1, "R9");
    rd_seq(2, "R9 wrap");
    send_byte(8'hFF, 0, "R7 released after nack");
    bus_stop();

    bus_start(); tag = "R11";
    for (int i = 0; i < 4; i++) begin
      wt(Q); m_low = i[0]; wt(H - Q); scl = 1; wt(H); scl = 0;
    end
    bus_start(); send_byte(8'hA1, 1, "R11"); rd_seq(1, "R11"); bus_stop();

    watch = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule